// File: doc/BRIEF.md
# Relocating Word Memory Port

This block is a 256-word by 16-bit main memory that is reached only through address relocation. The clients present 7-bit virtual addresses. Before any access, the port adds the contents of an 8-bit base register to the virtual address to form the real address. A single client port carries both reads and writes. Operand accesses and instruction fetches both use this port, so one base value confines a running program to a window of 128 words that may start anywhere in memory.

A second path serves program loading. A four-word buffer is taken in one cycle. Its words are then written, unchanged and unchecked, to four consecutive virtual addresses, one word per cycle, under the same relocation. The client port is locked out while this burst runs. Any access whose real address falls past the last word is refused, and an error pulse reports it.

Top module: `reloc_mem`

## Requirements
- R1: After reset the base register holds 0, and rvalid_o, err_o, ld_busy_o and ld_done_o are low.
- R2: A cycle with base_we_i high loads base_i into the base register. An access presented in that same cycle still uses the old base, and accesses in later cycles use the new one.
- R3: Every access goes to real address base + vaddr_i. A read request (req_i high, we_i low) returns the word on rdata_o with rvalid_o high in the following cycle, and err_o stays low when the real address is at most 255.
- R4: A write request (req_i high, we_i high) stores wdata_i at the clock edge that samples it, and does not raise rvalid_o. A later read of the same real address returns that word.
- R5: The virtual address is 7 bits wide. Virtual address 127 under base 128 reaches real word 255.
- R6: When base + vaddr_i exceeds 255, err_o pulses high for one cycle in the following cycle. A write is then dropped, with no wrap onto low memory. A read returns rvalid_o high with rdata_o equal to 0.
- R7: A ld_start_i pulse latches ld_buf_i. ld_busy_o is then high for exactly four cycles, during which word i (bits 16*i+15 down to 16*i) is written to real address base + ld_vaddr_i + i, for i = 0 to 3 in rising order.
- R8: ld_done_o is high for exactly one cycle, in the cycle after the fourth burst write, when ld_busy_o has fallen.
- R9: While ld_busy_o is high, client requests and ld_start_i are ignored: no read response, no write, no new burst.
- R10: A burst word whose real address exceeds 255 is dropped and raises err_o for one cycle after its write slot. The in-range words of the same burst are still written.
- R11: Burst words are stored exactly as given, with no checking of their values; 16'hFFFF and 16'h0000 are written like any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Load the base register |
| base_i | input | 8 | New base value |
| req_i | input | 1 | Client access request |
| we_i | input | 1 | 1 = write, 0 = read |
| vaddr_i | input | 7 | Client virtual address |
| wdata_i | input | 16 | Client write data |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response valid |
| err_o | output | 1 | Out-of-range access pulse |
| ld_start_i | input | 1 | Start a four-word load burst |
| ld_vaddr_i | input | 7 | Virtual start address of the burst |
| ld_buf_i | input | 64 | Four burst words, word 0 in the low bits |
| ld_busy_o | output | 1 | Burst in progress |
| ld_done_o | output | 1 | Burst finished pulse |

## Verification
The hardest situation to reach from the ports is a client request that arrives while a burst is already writing. In that case nothing may happen: no read response, and no write that silently lands in memory. To create it, the stimulus starts a burst and then drives a read, a write to a word preloaded with a known value, and a second start during the four busy cycles. It then shows that there was no response, that the preloaded word survives and that no extra busy period follows. A second burst is placed so that its last word crosses the top of memory. This shows the error appears in exactly the fourth slot while the first three words land.

// File: rtl/reloc_mem_pkg.sv
package reloc_mem_pkg;

    // Default geometry of the relocating memory.
    parameter int unsigned WORD_W_DEF  = 16;
    parameter int unsigned DEPTH_DEF   = 256;
    parameter int unsigned VADDR_W_DEF = 7;
    parameter int unsigned BASE_W_DEF  = 8;
    parameter int unsigned BURST_DEF   = 4;

    // Number of translation channels: client port and burst loader.
    parameter int unsigned N_CHAN = 2;
    parameter int unsigned CH_CLIENT = 0;
    parameter int unsigned CH_LOADER = 1;

endpackage

// File: rtl/reloc_mem_xlate.sv
module reloc_mem_xlate #(
    parameter int unsigned BASE_W = 8,
    parameter int unsigned OFF_W  = 8,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned REAL_W = $clog2(DEPTH)
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [REAL_W-1:0] real_o,
    output logic              oob_o
);
    localparam int unsigned MAX_W = (BASE_W > OFF_W) ? BASE_W : OFF_W;
    localparam int unsigned SUM_W = MAX_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum    = SUM_W'(base_i) + SUM_W'(off_i);
        oob_o  = (sum >= SUM_W'(DEPTH));
        real_o = sum[REAL_W-1:0];
    end
endmodule

// File: rtl/reloc_mem_loader.sv
module reloc_mem_loader #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned VADDR_W = 7,
    parameter int unsigned BURST   = 4,
    localparam int unsigned BUF_W  = WORD_W * BURST,
    localparam int unsigned IDX_W  = (BURST > 1) ? $clog2(BURST) : 1,
    localparam int unsigned OFF_W  = $clog2((1 << VADDR_W) + BURST)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [VADDR_W-1:0] vaddr_i,
    input  logic [BUF_W-1:0]   buf_i,
    output logic               wr_o,
    output logic [OFF_W-1:0]   off_o,
    output logic [WORD_W-1:0]  data_o,
    output logic               busy_o,
    output logic               done_o
);
    typedef struct packed {
        logic               busy;
        logic               done;
        logic [IDX_W-1:0]   idx;
        logic [VADDR_W-1:0] start;
        logic [BUF_W-1:0]   words;
    } ld_state_t;

    ld_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy  = 1'b1;
                s_d.idx   = '0;
                s_d.start = vaddr_i;
                s_d.words = buf_i;
            end
        end else if (s_q.idx == IDX_W'(BURST - 1)) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end else begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_o   = s_q.busy;
    assign off_o  = OFF_W'(s_q.start) + OFF_W'(s_q.idx);
    assign data_o = s_q.words[s_q.idx * WORD_W +: WORD_W];
    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
endmodule

// File: rtl/reloc_mem_array.sv
module reloc_mem_array #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned REAL_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [REAL_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [REAL_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] rdata_q, rdata_d;

    always_comb begin
        rdata_d = rdata_q;
        if (re_i) begin
            rdata_d = mem_q[raddr_i];
        end
    end

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/reloc_mem.sv
module reloc_mem
    import reloc_mem_pkg::*;
#(
    parameter int unsigned WORD_W  = WORD_W_DEF,
    parameter int unsigned DEPTH   = DEPTH_DEF,
    parameter int unsigned VADDR_W = VADDR_W_DEF,
    parameter int unsigned BASE_W  = BASE_W_DEF,
    parameter int unsigned BURST   = BURST_DEF,
    localparam int unsigned REAL_W = $clog2(DEPTH),
    localparam int unsigned BUF_W  = WORD_W * BURST,
    localparam int unsigned OFF_W  = $clog2((1 << VADDR_W) + BURST)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               base_we_i,
    input  logic [BASE_W-1:0]  base_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [VADDR_W-1:0] vaddr_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               rvalid_o,
    output logic               err_o,
    input  logic               ld_start_i,
    input  logic [VADDR_W-1:0] ld_vaddr_i,
    input  logic [BUF_W-1:0]   ld_buf_i,
    output logic               ld_busy_o,
    output logic               ld_done_o
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              rvalid;
        logic              rd_oob;
        logic              err;
    } port_state_t;

    port_state_t s_q, s_d;

    logic              ld_wr, ld_busy, ld_done;
    logic [OFF_W-1:0]  ld_off;
    logic [WORD_W-1:0] ld_data;
    logic [OFF_W-1:0]  ch_off  [N_CHAN];
    logic [REAL_W-1:0] ch_real [N_CHAN];
    logic              ch_oob  [N_CHAN];

    logic              cli_ok;
    logic              mem_we, mem_re;
    logic [REAL_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;

    reloc_mem_loader #(
        .WORD_W (WORD_W),
        .VADDR_W(VADDR_W),
        .BURST  (BURST)
    ) loader_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(ld_start_i),
        .vaddr_i(ld_vaddr_i),
        .buf_i  (ld_buf_i),
        .wr_o   (ld_wr),
        .off_o  (ld_off),
        .data_o (ld_data),
        .busy_o (ld_busy),
        .done_o (ld_done)
    );

    assign ch_off[CH_CLIENT] = OFF_W'(vaddr_i);
    assign ch_off[CH_LOADER] = ld_off;

    // One relocation adder per address source, all sharing the base register.
    for (genvar g = 0; g < N_CHAN; g++) begin : g_xlate
        reloc_mem_xlate #(
            .BASE_W(BASE_W),
            .OFF_W (OFF_W),
            .DEPTH (DEPTH)
        ) xlate_i (
            .base_i(s_q.base),
            .off_i (ch_off[g]),
            .real_o(ch_real[g]),
            .oob_o (ch_oob[g])
        );
    end

    always_comb begin
        s_d    = s_q;
        cli_ok = req_i && !ld_busy;
        if (base_we_i) begin
            s_d.base = base_i;
        end
        s_d.rvalid = cli_ok && !we_i;
        s_d.rd_oob = cli_ok && !we_i && ch_oob[CH_CLIENT];
        s_d.err    = (cli_ok && ch_oob[CH_CLIENT]) || (ld_wr && ch_oob[CH_LOADER]);

        // Write port: the burst owns it while busy; out-of-range writes are dropped.
        if (ld_wr) begin
            mem_we    = !ch_oob[CH_LOADER];
            mem_waddr = ch_real[CH_LOADER];
            mem_wdata = ld_data;
        end else begin
            mem_we    = cli_ok && we_i && !ch_oob[CH_CLIENT];
            mem_waddr = ch_real[CH_CLIENT];
            mem_wdata = wdata_i;
        end
        mem_re = cli_ok && !we_i && !ch_oob[CH_CLIENT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    reloc_mem_array #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH)
    ) array_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (mem_we),
        .waddr_i(mem_waddr),
        .wdata_i(mem_wdata),
        .re_i   (mem_re),
        .raddr_i(ch_real[CH_CLIENT]),
        .rdata_o(mem_rdata)
    );

    assign rdata_o   = s_q.rd_oob ? '0 : mem_rdata;
    assign rvalid_o  = s_q.rvalid;
    assign err_o     = s_q.err;
    assign ld_busy_o = ld_busy;
    assign ld_done_o = ld_done;
endmodule

// File: rtl/reloc_mem_chk.sv
module reloc_mem_chk #(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned VADDR_W = 7,
    parameter int unsigned BASE_W  = 8,
    parameter int unsigned BURST   = 4,
    localparam int unsigned SUM_W  = ((BASE_W > VADDR_W) ? BASE_W : VADDR_W) + 1,
    localparam int unsigned CNT_W  = $clog2(BURST + 2)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               base_we_i,
    input logic [BASE_W-1:0]  base_i,
    input logic               req_i,
    input logic               we_i,
    input logic [VADDR_W-1:0] vaddr_i,
    input logic               rvalid_o,
    input logic               err_o,
    input logic               ld_busy_o,
    input logic               ld_done_o
);
    logic [BASE_W-1:0] base_sh_q;
    logic [CNT_W-1:0]  busy_cnt_q;
    logic [SUM_W-1:0]  cli_sum;
    logic              cli_take;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            base_sh_q  <= '0;
            busy_cnt_q <= '0;
        end else begin
            if (base_we_i) base_sh_q <= base_i;
            busy_cnt_q <= ld_busy_o ? busy_cnt_q + 1'b1 : '0;
        end
    end

    assign cli_sum  = SUM_W'(base_sh_q) + SUM_W'(vaddr_i);
    assign cli_take = req_i && !ld_busy_o;

    AST_READ_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cli_take && !we_i |=> rvalid_o); // R3
    AST_INRANGE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cli_take && (cli_sum < SUM_W'(DEPTH)) |=> !err_o); // R3
    AST_WRITE_NO_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i && we_i |=> !rvalid_o); // R4
    AST_OOB_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cli_take && (cli_sum >= SUM_W'(DEPTH)) |=> err_o); // R6
    AST_BURST_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_done_o |-> (busy_cnt_q == CNT_W'(BURST))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_done_o |=> !ld_done_o); // R8
    AST_BUSY_NO_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_busy_o |=> !rvalid_o); // R9
endmodule

bind reloc_mem reloc_mem_chk #(
    .DEPTH  (DEPTH),
    .VADDR_W(VADDR_W),
    .BASE_W (BASE_W),
    .BURST  (BURST)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .base_we_i(base_we_i),
    .base_i   (base_i),
    .req_i    (req_i),
    .we_i     (we_i),
    .vaddr_i  (vaddr_i),
    .rvalid_o (rvalid_o),
    .err_o    (err_o),
    .ld_busy_o(ld_busy_o),
    .ld_done_o(ld_done_o)
);

// File: tb/reloc_mem_tb_top.sv
module reloc_mem_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        base_we_i = 1'b0;
    logic [7:0]  base_i = '0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [6:0]  vaddr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        rvalid_o, err_o;
    logic        ld_start_i = 1'b0;
    logic [6:0]  ld_vaddr_i = '0;
    logic [63:0] ld_buf_i = '0;
    logic        ld_busy_o, ld_done_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk_i = ~clk_i;

    reloc_mem dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .base_we_i(base_we_i), .base_i(base_i),
        .req_i(req_i), .we_i(we_i), .vaddr_i(vaddr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o),
        .ld_start_i(ld_start_i), .ld_vaddr_i(ld_vaddr_i), .ld_buf_i(ld_buf_i),
        .ld_busy_o(ld_busy_o), .ld_done_o(ld_done_o)
    );

    typedef struct packed {
        logic [7:0]  base;
        logic        wr;
        logic [6:0]  va;
        logic [15:0] data;
        logic [15:0] expd;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'd0,   1'b1, 7'd0,   16'h0A0A, 16'h0000, 1'b0, 4'd4},  // R4 seed real 0
        '{8'd0,   1'b1, 7'd5,   16'h1234, 16'h0000, 1'b0, 4'd4},  // R4
        '{8'd0,   1'b0, 7'd5,   16'h0000, 16'h1234, 1'b0, 4'd4},  // R4 read back
        '{8'd16,  1'b1, 7'd2,   16'hBEEF, 16'h0000, 1'b0, 4'd3},  // R3 real 18
        '{8'd0,   1'b0, 7'd18,  16'h0000, 16'hBEEF, 1'b0, 4'd3},  // R3
        '{8'd128, 1'b1, 7'd127, 16'h7FFF, 16'h0000, 1'b0, 4'd5},  // R5 real 255
        '{8'd200, 1'b0, 7'd55,  16'h0000, 16'h7FFF, 1'b0, 4'd5},  // R5
        '{8'd129, 1'b1, 7'd127, 16'hDEAD, 16'h0000, 1'b1, 4'd6},  // R6 real 256
        '{8'd0,   1'b0, 7'd0,   16'h0000, 16'h0A0A, 1'b0, 4'd6},  // R6 no wrap
        '{8'd255, 1'b0, 7'd1,   16'h0000, 16'h0000, 1'b1, 4'd6},  // R6 read oob
        '{8'd40,  1'b1, 7'd0,   16'h4040, 16'h0000, 1'b0, 4'd2},  // R2 seed real 40
        '{8'd150, 1'b1, 7'd0,   16'h1500, 16'h0000, 1'b0, 4'd9}   // R9 seed real 150
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic set_base(input logic [7:0] b);
        @(negedge clk_i);
        base_we_i = 1'b1;
        base_i    = b;
        @(negedge clk_i);
        base_we_i = 1'b0;
    endtask

    // Drive one access; on return the response cycle is current.
    task automatic access(input logic wr, input logic [6:0] va, input logic [15:0] d);
        @(negedge clk_i);
        req_i = 1'b1; we_i = wr; vaddr_i = va; wdata_i = d;
        @(negedge clk_i);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [6:0] va, input logic [15:0] expv);
        access(1'b0, va, 16'h0);
        check(req, {15'b0, rvalid_o}, 16'h1);
        check(req, rdata_o, expv);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: quiet outputs under and after reset
        check("R1", {12'b0, rvalid_o, err_o, ld_busy_o, ld_done_o}, 16'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", {12'b0, rvalid_o, err_o, ld_busy_o, ld_done_o}, 16'h0);
        // R1: base is 0 after reset, so this write lands at real 3
        access(1'b1, 7'd3, 16'h3333);

        for (int i = 0; i < NV; i++) begin
            set_base(VEC[i].base);
            access(VEC[i].wr, VEC[i].va, VEC[i].data);
            check($sformatf("R%0d vec%0d rvalid", VEC[i].req, i), {15'b0, rvalid_o}, {15'b0, !VEC[i].wr});
            check($sformatf("R%0d vec%0d err", VEC[i].req, i), {15'b0, err_o}, {15'b0, VEC[i].eerr});
            if (!VEC[i].wr)
                check($sformatf("R%0d vec%0d data", VEC[i].req, i), rdata_o, VEC[i].expd);
        end

        set_base(8'd0);
        read_chk("R1", 7'd3, 16'h3333);

        // R2: base load and read in the same cycle use the old base (0)
        @(negedge clk_i);
        base_we_i = 1'b1; base_i = 8'd40;
        req_i = 1'b1; we_i = 1'b0; vaddr_i = 7'd0;
        @(negedge clk_i);
        base_we_i = 1'b0; req_i = 1'b0;
        check("R2", rdata_o, 16'h0A0A);
        read_chk("R2", 7'd0, 16'h4040);

        // R7/R8/R9/R11: burst of four words at base 50, start 10
        set_base(8'd50);
        @(negedge clk_i);
        ld_start_i = 1'b1; ld_vaddr_i = 7'd10;
        ld_buf_i = {16'h2222, 16'h0000, 16'hFFFF, 16'h1111};
        @(negedge clk_i);
        ld_start_i = 1'b0;
        check("R7", {14'b0, ld_busy_o, ld_done_o}, 16'h2);
        req_i = 1'b1; we_i = 1'b0; vaddr_i = 7'd0;
        @(negedge clk_i);
        check("R7", {14'b0, ld_busy_o, ld_done_o}, 16'h2);
        check("R9", {15'b0, rvalid_o}, 16'h0);
        we_i = 1'b1; vaddr_i = 7'd100; wdata_i = 16'hAAAA;
        @(negedge clk_i);
        check("R7", {14'b0, ld_busy_o, ld_done_o}, 16'h2);
        req_i = 1'b0; we_i = 1'b0;
        ld_start_i = 1'b1; ld_vaddr_i = 7'd60;
        @(negedge clk_i);
        check("R7", {14'b0, ld_busy_o, ld_done_o}, 16'h2);
        ld_start_i = 1'b0;
        @(negedge clk_i);
        check("R8", {14'b0, ld_busy_o, ld_done_o}, 16'h1);
        @(negedge clk_i);
        check("R8", {14'b0, ld_busy_o, ld_done_o}, 16'h0);
        check("R9", {15'b0, ld_busy_o}, 16'h0);
        read_chk("R7", 7'd10, 16'h1111);
        read_chk("R11", 7'd11, 16'hFFFF);
        read_chk("R11", 7'd12, 16'h0000);
        read_chk("R7", 7'd13, 16'h2222);
        read_chk("R9", 7'd100, 16'h1500);

        // R10: burst at base 250 start 3, last word reaches real 256
        set_base(8'd250);
        @(negedge clk_i);
        ld_start_i = 1'b1; ld_vaddr_i = 7'd3;
        ld_buf_i = {16'hA4A4, 16'hA3A3, 16'hA2A2, 16'hA1A1};
        @(negedge clk_i);
        ld_start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_i);
            check("R10", {15'b0, err_o}, 16'h0);
        end
        @(negedge clk_i);
        check("R10", {14'b0, err_o, ld_done_o}, 16'h3);
        read_chk("R10", 7'd3, 16'hA1A1);
        read_chk("R10", 7'd4, 16'hA2A2);
        read_chk("R10", 7'd5, 16'hA3A3);
        set_base(8'd0);
        read_chk("R10", 7'd0, 16'h0A0A);

        repeat (2) @(negedge clk_i);
        finish_run();
    end
endmodule